// File: doc/BRIEF.md
# Flash Program/Erase Status Polling Responder

This block stands in for the status-read side of a NOR-style flash while an embedded program or erase runs. A host issues commands on a small command port: program (address plus byte), erase (a mask of sectors to clear), suspend and resume. The block checks each command against the sector-protect mask and tracks the operation's lifetime with cycle counters whose lengths are parameters. A small internal byte array holds the contents so that reads after completion return real data. An active-low ready/busy pin reports whether an embedded operation is in progress.

Host reads return one byte on an 8-bit bus. While an operation runs, bit 7 carries data-complement polling status. During programming it is the inverse of bit 7 of the byte being written. During erase it is 0. In erase suspend, or once the erase is done, it is 1. Both the command port and the read port are single-cycle strobes and never apply back-pressure. A command that is not accepted in the current state is dropped. A read request always yields exactly one result, one cycle later.

Top module: `flash_poll_resp`

## Requirements
- R1: After synchronous reset `ready_nbusy` is 1, the block is in read mode, and every byte reads 0xFF.
- R2: A program command (`cmd_op`=1) to an unprotected sector holds `ready_nbusy` low for exactly PROG_CYC cycles. Reads during that window return {~bit7 of the programmed byte, 7'b0}.
- R3: At program completion the stored byte becomes old AND new. The first read after completion returns {stored bit 7, 7'b0}, and the next read returns the full stored byte.
- R4: An erase command (`cmd_op`=2, nonzero `cmd_sel`; sector = the top log2(NSECT) address bits) holds `ready_nbusy` low for ERASE_CYC active cycles, and reads return 0x00. Afterwards every byte of each erased sector is 0xFF, and the first read shows only bit 7.
- R5: Suspend (`cmd_op`=3) during erase raises `ready_nbusy` and freezes the remaining erase time. Reads in erasing sectors return 0x80, and reads elsewhere return stored data. Resume (`cmd_op`=4) finishes the remaining cycles.
- R6: In erase suspend, a program command to a sector that is neither protected nor erasing runs with the R2/R3 status rules. The block then returns to suspend, not to read mode.
- R7: A program command to a protected sector holds busy for PPROT_CYC cycles with complement status. It then returns to read mode with the array unchanged and no partial first read.
- R8: An erase whose selected sectors are all protected holds busy for EPROT_CYC cycles with bit 7 at 0. It then returns to read mode with the array unchanged.
- R9: With partially protected selection, only the unprotected selected sectors are erased.
- R10: Commands not listed as legal are ignored: any command while busy, suspend or resume in read mode, and an erase with an all-zero mask.
- R11: `rd_valid` rises exactly one cycle after each `rd_en`, and `rd_data` is captured from the state current at that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | 1 program, 2 erase, 3 suspend, 4 resume; others ignored |
| cmd_addr | input | ADDR_W | Program byte address |
| cmd_data | input | 8 | Program byte |
| cmd_sel | input | NSECT | Erase sector-select mask |
| prot_mask | input | NSECT | Sector-protect mask, sampled with each command |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read byte address |
| rd_valid | output | 1 | Read result valid, one cycle after rd_en |
| rd_data | output | 8 | Read result: data or polling status |
| ready_nbusy | output | 1 | High when ready, low while an embedded operation runs |

## Verification
Programs are driven with data whose bit 7 is 0 and with data whose bit 7 is 1. This separates a true complement from a constant status bit, and a repeat program to one address separates AND-merging from overwriting. Erases are run with no protection, partial protection and full protection, which separates the normal, filtered and dummy-window paths. A suspend in the middle of an erase with a program inside it checks that the remaining count is frozen and that control returns to suspend. Stray suspend, resume, empty-mask and overlapping commands show that illegal commands leave no trace.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  localparam logic [2:0] OP_PROG   = 3'd1;
  localparam logic [2:0] OP_ERASE  = 3'd2;
  localparam logic [2:0] OP_SUSP   = 3'd3;
  localparam logic [2:0] OP_RESUME = 3'd4;

  typedef enum logic [2:0] {
    S_READ,
    S_PROG,
    S_ERASE,
    S_ESUSP,
    S_SPROG,
    S_PPROT,
    S_EPROT
  } st_e;

  function automatic logic is_busy(st_e s);
    case (s)
      S_PROG, S_ERASE, S_SPROG, S_PPROT, S_EPROT: is_busy = 1'b1;
      default:                                    is_busy = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fpr_seq.sv
module fpr_seq
  import fpr_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NSECT     = 4,
  parameter int PROG_CYC  = 12,
  parameter int ERASE_CYC = 60,
  parameter int PPROT_CYC = 5,
  parameter int EPROT_CYC = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic [NSECT-1:0]  cmd_sel,
  input  logic [NSECT-1:0]  prot_mask,
  output st_e               st,
  output logic              pbit7,
  output logic [NSECT-1:0]  emask,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              er_en,
  output logic              done
);

  localparam int SECT_W = $clog2(NSECT);
  localparam int MAX_A  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAX_B  = (PPROT_CYC > EPROT_CYC) ? PPROT_CYC : EPROT_CYC;
  localparam int MAXC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAXC + 1);

  logic [CNT_W-1:0]  cnt, ecnt;
  logic [ADDR_W-1:0] paddr;
  logic [7:0]        pdata;
  logic [SECT_W-1:0] csect;
  logic [NSECT-1:0]  eff;
  logic              is_prog, is_erase;

  assign csect    = cmd_addr[ADDR_W-1 -: SECT_W];
  assign eff      = cmd_sel & ~prot_mask;
  assign is_prog  = cmd_valid && (cmd_op == OP_PROG);
  assign is_erase = cmd_valid && (cmd_op == OP_ERASE) && (cmd_sel != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_READ;
      cnt   <= '0;
      ecnt  <= '0;
      paddr <= '0;
      pdata <= '0;
      emask <= '0;
    end else begin
      case (st)
        S_READ: begin
          if (is_prog) begin
            paddr <= cmd_addr;
            pdata <= cmd_data;
            if (prot_mask[csect]) begin
              st  <= S_PPROT;
              cnt <= CNT_W'(PPROT_CYC - 1);
            end else begin
              st  <= S_PROG;
              cnt <= CNT_W'(PROG_CYC - 1);
            end
          end else if (is_erase) begin
            if (eff == '0) begin
              st  <= S_EPROT;
              cnt <= CNT_W'(EPROT_CYC - 1);
            end else begin
              st    <= S_ERASE;
              ecnt  <= CNT_W'(ERASE_CYC - 1);
              emask <= eff;
            end
          end
        end
        S_PROG, S_PPROT, S_EPROT: begin
          if (cnt == '0) st <= S_READ;
          else           cnt <= cnt - 1'b1;
        end
        S_SPROG: begin
          if (cnt == '0) st <= S_ESUSP;
          else           cnt <= cnt - 1'b1;
        end
        S_ERASE: begin
          if (ecnt == '0) begin
            st    <= S_READ;
            emask <= '0;
          end else if (cmd_valid && cmd_op == OP_SUSP) begin
            st <= S_ESUSP;
          end else begin
            ecnt <= ecnt - 1'b1;
          end
        end
        S_ESUSP: begin
          if (cmd_valid && cmd_op == OP_RESUME) begin
            st <= S_ERASE;
          end else if (is_prog && !prot_mask[csect] && !emask[csect]) begin
            st    <= S_SPROG;
            paddr <= cmd_addr;
            pdata <= cmd_data;
            cnt   <= CNT_W'(PROG_CYC - 1);
          end
        end
        default: st <= S_READ;
      endcase
    end
  end

  assign wr_en   = (st == S_PROG || st == S_SPROG) && (cnt == '0);
  assign wr_addr = paddr;
  assign wr_data = pdata;
  assign pbit7   = pdata[7];
  assign er_en   = (st == S_ERASE) && (ecnt == '0);
  assign done    = wr_en || er_en;

  // R2: an accepted program leaves read mode on the next cycle
  p_prog_leaves_read_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_READ && is_prog) |=> (st != S_READ));

  // R5: remaining erase time is frozen while suspended
  p_susp_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_ESUSP) |=> $stable(ecnt));

  // R10: a running program does not take a new target
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
    (st == S_PROG) |=> ($stable(paddr) && $stable(pdata)));

  // R4: erase completion returns to read mode
  p_erase_done_r4: assert property (@(posedge clk) disable iff (rst)
    er_en |=> (st == S_READ));

  // R6: a program inside suspend returns to suspend
  p_sprog_back_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_SPROG && cnt == '0) |=> (st == S_ESUSP));

endmodule

// File: rtl/fpr_array.sv
module fpr_array #(
  parameter int ADDR_W = 6,
  parameter int NSECT  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              er_en,
  input  logic [NSECT-1:0]  er_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_byte
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int SPAN  = DEPTH / NSECT;

  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] hit_er, hit_wr;

  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    assign hit_er[g] = er_en && er_mask[g / SPAN];
    assign hit_wr[g] = wr_en && (wr_addr == ADDR_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst || hit_er[i]) mem[i] <= 8'hFF;
      else if (hit_wr[i])   mem[i] <= mem[i] & wr_data;
    end
  end

  assign rd_byte = mem[rd_addr];

  // R4: an erase and a program never commit in the same cycle
  p_one_update_r4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && er_en));

  // R3: a program can only clear bits of the stored byte
  p_and_merge_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_addr == wr_addr) |=> ((rd_byte & ~$past(rd_byte)) == 8'h00 || rd_addr != $past(rd_addr)));

endmodule

// File: rtl/fpr_rdport.sv
module fpr_rdport
  import fpr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NSECT  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  st_e               st,
  input  logic              pbit7,
  input  logic [NSECT-1:0]  emask,
  input  logic [7:0]        stored,
  input  logic              done,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);

  localparam int SECT_W = $clog2(NSECT);

  logic              lag;
  logic [7:0]        nxt;
  logic [SECT_W-1:0] rsect;

  assign rsect = rd_addr[ADDR_W-1 -: SECT_W];

  always_comb begin
    if (lag) begin
      nxt = {stored[7], 7'b0};
    end else begin
      case (st)
        S_READ:                   nxt = stored;
        S_PROG, S_SPROG, S_PPROT: nxt = {~pbit7, 7'b0};
        S_ERASE, S_EPROT:         nxt = 8'h00;
        S_ESUSP:                  nxt = emask[rsect] ? 8'h80 : stored;
        default:                  nxt = stored;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
      lag      <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= nxt;
      if (done)       lag <= 1'b1;
      else if (rd_en) lag <= 1'b0;
    end
  end

  // R11: one result per request, one cycle later
  p_rd_latency_r11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R4: a read during erase shows bit 7 low
  p_erase_status_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !lag && st == S_ERASE) |=> (rd_data[7] == 1'b0));

  // R2: a read during programming shows the complement
  p_prog_status_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !lag && st == S_PROG) |=> (rd_data[7] == !$past(pbit7)));

  // R3: the partial read happens once
  p_lag_once_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && lag && !done) |=> !lag);

endmodule

// File: rtl/flash_poll_resp.sv
module flash_poll_resp
  import fpr_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NSECT     = 4,
  parameter int PROG_CYC  = 12,
  parameter int ERASE_CYC = 60,
  parameter int PPROT_CYC = 5,
  parameter int EPROT_CYC = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic [NSECT-1:0]  cmd_sel,
  input  logic [NSECT-1:0]  prot_mask,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              ready_nbusy
);

  st_e               st;
  logic              pbit7, wr_en, er_en, done;
  logic [NSECT-1:0]  emask;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data, stored;

  fpr_seq #(
    .ADDR_W(ADDR_W), .NSECT(NSECT), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .PPROT_CYC(PPROT_CYC), .EPROT_CYC(EPROT_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_sel(cmd_sel),
    .prot_mask(prot_mask), .st(st), .pbit7(pbit7), .emask(emask),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .er_en(er_en), .done(done)
  );

  fpr_array #(.ADDR_W(ADDR_W), .NSECT(NSECT)) u_arr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .er_en(er_en), .er_mask(emask),
    .rd_addr(rd_addr), .rd_byte(stored)
  );

  fpr_rdport #(.ADDR_W(ADDR_W), .NSECT(NSECT)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .st(st),
    .pbit7(pbit7), .emask(emask), .stored(stored), .done(done),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign ready_nbusy = !is_busy(st);

  // R1: ready after reset
  p_ready_after_reset_r1: assert property (@(posedge clk)
    $fell(rst) |-> ready_nbusy);

  // R10: suspend or resume in read mode keeps the pin high
  p_stray_cmd_r10: assert property (@(posedge clk) disable iff (rst)
    (ready_nbusy && cmd_valid && (cmd_op == OP_SUSP || cmd_op == OP_RESUME)
     && st == S_READ) |=> ready_nbusy);

endmodule

// File: tb/sim_flash_poll_resp.sv
module sim_flash_poll_resp;

  localparam int AW = 6, NS = 4, PC = 12, EC = 60, PPC = 5, EPC = 25;

  logic       clk = 1'b0, rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [5:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic [3:0] cmd_sel = '0, prot_mask = '0;
  logic       rd_en = 1'b0;
  logic [5:0] rd_addr = '0;
  logic       rd_valid, ready_nbusy;
  logic [7:0] rd_data;

  always #10 clk = ~clk;

  flash_poll_resp #(.ADDR_W(AW), .NSECT(NS), .PROG_CYC(PC), .ERASE_CYC(EC),
                    .PPROT_CYC(PPC), .EPROT_CYC(EPC)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_sel(cmd_sel),
    .prot_mask(prot_mask), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .ready_nbusy(ready_nbusy)
  );

  int    checks = 0, errors = 0;
  string cur_req = "R1";

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // behavioural reference: 0 read,1 prog,2 erase,3 susp,4 susp-prog,5 prot-prog,6 prot-erase
  int       m_st, m_cnt, m_ecnt;
  bit [7:0] m_mem [64];
  bit       m_lag, e_rv;
  bit [7:0] m_pd, e_rd;
  int       m_pa;
  bit [3:0] m_em;

  function automatic bit m_busy();
    return m_st == 1 || m_st == 2 || m_st == 4 || m_st == 5 || m_st == 6;
  endfunction

  function automatic bit [7:0] m_read(int a);
    if (m_lag) return {m_mem[a][7], 7'b0};
    if (m_st == 1 || m_st == 4 || m_st == 5) return {~m_pd[7], 7'b0};
    if (m_st == 2 || m_st == 6) return 8'h00;
    if (m_st == 3 && m_em[a / 16]) return 8'h80;
    return m_mem[a];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_ecnt = 0; m_lag = 0; e_rv = 0; e_rd = 0;
      m_pd = 0; m_pa = 0; m_em = 0;
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
    end else begin
      bit nl;
      e_rv = rd_en;
      if (rd_en) e_rd = m_read(int'(rd_addr));
      nl = rd_en ? 1'b0 : m_lag;
      case (m_st)
        0: if (cmd_valid && cmd_op == 3'd1) begin
             m_pa = int'(cmd_addr); m_pd = cmd_data;
             if (prot_mask[cmd_addr[5:4]]) begin m_st = 5; m_cnt = PPC; end
             else begin m_st = 1; m_cnt = PC; end
           end else if (cmd_valid && cmd_op == 3'd2 && cmd_sel != 0) begin
             if ((cmd_sel & ~prot_mask) == 0) begin m_st = 6; m_cnt = EPC; end
             else begin m_st = 2; m_ecnt = EC; m_em = cmd_sel & ~prot_mask; end
           end
        1, 4, 5, 6: begin
             m_cnt--;
             if (m_cnt == 0) begin
               if (m_st == 1 || m_st == 4) begin
                 m_mem[m_pa] = m_mem[m_pa] & m_pd; nl = 1;
               end
               m_st = (m_st == 4) ? 3 : 0;
             end
           end
        2: if (m_ecnt == 1) begin
             for (int i = 0; i < 64; i++) if (m_em[i / 16]) m_mem[i] = 8'hFF;
             m_em = 0; m_st = 0; nl = 1; m_ecnt = 0;
           end else if (cmd_valid && cmd_op == 3'd3) m_st = 3;
           else m_ecnt--;
        3: if (cmd_valid && cmd_op == 3'd4) m_st = 2;
           else if (cmd_valid && cmd_op == 3'd1 && !prot_mask[cmd_addr[5:4]]
                    && !m_em[cmd_addr[5:4]]) begin
             m_pa = int'(cmd_addr); m_pd = cmd_data; m_st = 4; m_cnt = PC;
           end
        default: m_st = 0;
      endcase
      m_lag = nl;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk({cur_req, " ready pin"}, int'(ready_nbusy), int'(!m_busy()));
      chk({cur_req, " rd_valid (R11)"}, int'(rd_valid), int'(e_rv));
      if (e_rv) chk({cur_req, " rd_data"}, int'(rd_data), int'(e_rd));
    end
  end

  task automatic cmd(logic [2:0] op, logic [5:0] a, logic [7:0] d, logic [3:0] s);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_sel = s;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic rd(logic [5:0] a, int exp, string req);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    chk("R11 valid", int'(rd_valid), 1);
    chk(req, int'(rd_data), exp);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready_nbusy && n < 1000) begin n++; @(negedge clk); end
  endtask

  bit finished = 0;

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 ready", int'(ready_nbusy), 1);
    rd(6'd0, 8'hFF, "R1 erased array");

    cur_req = "R2";
    cmd(3'd1, 6'd5, 8'h3C, 4'h0);
    wait_ready(n);
    chk("R2 busy length", n, PC);
    cur_req = "R3";
    rd(6'd5, 8'h00, "R3 first read bit7 only");
    rd(6'd5, 8'h3C, "R3 full byte");

    cur_req = "R10";
    cmd(3'd1, 6'd5, 8'hA5, 4'h0);
    rd(6'd5, 8'h00, "R2 complement of bit7=1");
    cmd(3'd1, 6'd6, 8'h00, 4'h0);
    wait_ready(n);
    rd(6'd5, 8'h00, "R3 lag read");
    rd(6'd5, 8'h24, "R3 AND merge");
    rd(6'd6, 8'hFF, "R10 busy program ignored");

    cur_req = "R7";
    prot_mask = 4'b0010;
    cmd(3'd1, 6'd20, 8'h00, 4'h0);
    rd(6'd20, 8'h80, "R7 complement status");
    wait_ready(n);
    chk("R7 busy length", n + 1, PPC);
    rd(6'd20, 8'hFF, "R7 unchanged no lag");

    cur_req = "R8";
    prot_mask = 4'b0000;
    cmd(3'd1, 6'd20, 8'h11, 4'h0);
    wait_ready(n);
    rd(6'd20, 8'h00, "R3 lag");
    prot_mask = 4'b0010;
    cmd(3'd2, 6'd0, 8'h00, 4'b0010);
    wait_ready(n);
    chk("R8 busy length", n, EPC);
    rd(6'd20, 8'h11, "R8 array unchanged");

    cur_req = "R9";
    cmd(3'd2, 6'd0, 8'h00, 4'b0011);
    rd(6'd5, 8'h00, "R4 erase status");
    wait_ready(n);
    rd(6'd5, 8'h80, "R4 lag read");
    rd(6'd5, 8'hFF, "R9 unprotected erased");
    rd(6'd20, 8'h11, "R9 protected kept");

    cur_req = "R5";
    prot_mask = 4'b0000;
    cmd(3'd1, 6'd40, 8'h0F, 4'h0); wait_ready(n); rd(6'd40, 8'h00, "R3 lag");
    cmd(3'd1, 6'd50, 8'h70, 4'h0); wait_ready(n); rd(6'd50, 8'h00, "R3 lag");
    cmd(3'd2, 6'd0, 8'h00, 4'b0100);
    repeat (10) @(negedge clk);
    cmd(3'd3, 6'd0, 8'h00, 4'h0);
    chk("R5 ready in suspend", int'(ready_nbusy), 1);
    rd(6'd40, 8'h80, "R5 erasing sector status");
    rd(6'd50, 8'h70, "R5 other sector data");
    cur_req = "R6";
    cmd(3'd1, 6'd51, 8'hD5, 4'h0);
    chk("R6 busy", int'(ready_nbusy), 0);
    rd(6'd51, 8'h00, "R6 complement status");
    wait_ready(n);
    rd(6'd51, 8'h80, "R6 lag read");
    rd(6'd51, 8'hD5, "R6 programmed");
    rd(6'd40, 8'h80, "R6 back in suspend");
    cur_req = "R5";
    repeat (20) @(negedge clk);
    chk("R5 frozen", int'(ready_nbusy), 1);
    cmd(3'd4, 6'd0, 8'h00, 4'h0);
    wait_ready(n);
    chk("R5 remaining time", n, EC - 10);
    rd(6'd40, 8'h80, "R4 lag");
    rd(6'd40, 8'hFF, "R4 erased");
    rd(6'd50, 8'h70, "R4 other sector kept");

    cur_req = "R4";
    cmd(3'd2, 6'd0, 8'h00, 4'b1000);
    wait_ready(n);
    chk("R4 busy length", n, EC);
    rd(6'd50, 8'h80, "R4 lag");
    rd(6'd50, 8'hFF, "R4 sector erased");

    cur_req = "R10";
    cmd(3'd3, 6'd0, 8'h00, 4'h0);
    chk("R10 suspend ignored", int'(ready_nbusy), 1);
    cmd(3'd4, 6'd0, 8'h00, 4'h0);
    chk("R10 resume ignored", int'(ready_nbusy), 1);
    cmd(3'd2, 6'd0, 8'h00, 4'b0000);
    chk("R10 empty erase ignored", int'(ready_nbusy), 1);
    rd(6'd20, 8'h11, "R10 array intact");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule